// File: doc/BRIEF.md
# DMA Channel Control and Sequencer

This block is one DMA channel. It holds a source pointer, a destination pointer, a 16-bit transfer count and a 16-bit control word, all loaded through a simple write port and visible on a read port. From the control word and two request inputs (a request pin and a timer request), it decides when a transfer may start. It then raises a bus-transfer request towards a bus model. The bus model returns a one-cycle acknowledge when it has done the transfer. On each acknowledge the channel moves both pointers by one byte or one word and decrements the count. It stops at terminal count according to the synchronization mode and pulses an interrupt request when a terminal count completes with interrupts enabled.

The sequencer has three states. IDLE means the channel is disabled. ARMED means the channel is enabled and waiting for a request. BUS means a transfer request is outstanding. The transitions are:
- IDLE to ARMED: the start bit becomes 1.
- ARMED to IDLE: the start bit is 0.
- ARMED to BUS: the request condition holds.
- BUS to ARMED: an acknowledge that does not end the run.
- BUS to IDLE: an acknowledge that ends the run and clears the start bit.

Address space selection and byte or word width are not acted on inside the channel. They are passed out as attribute bits for the bus model.

Top module: `dmach_top`

## Requirements
- R1: After reset the control word reads 00C0h (sync field 11, all other bits 0), both pointers and the count read 0, and `xfer_req` and `irq` are 0.
- R2: A write to the control word (select 0) changes the start bit (bit 1) only when bit 2 is 1 in the same write; otherwise the start bit keeps its value. Bit 2 always reads back as 0.
- R3: After each acknowledged transfer each pointer moves by 1 when bit 0 is 0, or by 2 when bit 0 is 1. The source pointer rises if bit 10 is set without bit 11 and falls if bit 11 is set without bit 10. The destination pointer does the same with bits 13 (up) and 14 (down). Equal up and down bits hold the pointer.
- R4: `xfer_src_mem` follows bit 12, `xfer_dst_mem` follows bit 15 and `xfer_word` follows bit 0 (1 = memory, 1 = word).
- R5: The count decrements by one on every acknowledged transfer and wraps from 0 to FFFFh.
- R6: With sync field 00 (unsynchronized) and bit 4 clear, transfers run back to back and the channel stops when the count reaches 0, whatever bit 9 holds. Stopping clears the start bit.
- R7: With sync field 01 (source) or 10 (destination), a transfer starts only while `drq_in` is 1. The channel stops at count 0 only if bit 9 is 1, and otherwise keeps running with the count wrapping.
- R8: `irq` is a one-cycle pulse, in the cycle after the acknowledge that brings the count to 0 and stops the channel, only when bits 8 and 9 were both 1.
- R9: With bit 4 set, requests come from `tmr_req` alone, the sync field (even 11) is ignored, and bit 9 decides whether the count stops at 0.
- R10: With bit 3 set, `drq_in` is ignored and a synchronized channel issues no transfer.
- R11: With sync field 11 and bit 4 clear, the channel issues no transfer.
- R12: `xfer_req` stays high with stable addresses until `xfer_ack`, and each acknowledge completes exactly one transfer.
- R13: A register write in the same cycle as an acknowledge takes precedence over the pointer, count or start-bit update of that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 source, 2 destination, 3 count |
| wr_data | input | ADDR_W | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | ADDR_W | Read data, zero-extended |
| drq_in | input | 1 | Request pin |
| tmr_req | input | 1 | Timer request |
| xfer_ack | input | 1 | Transfer done, one cycle |
| xfer_req | output | 1 | Transfer request to the bus model |
| xfer_src_addr | output | ADDR_W | Source pointer |
| xfer_dst_addr | output | ADDR_W | Destination pointer |
| xfer_src_mem | output | 1 | Source is memory (1) or I/O (0) |
| xfer_dst_mem | output | 1 | Destination is memory (1) or I/O (0) |
| xfer_word | output | 1 | Word (1) or byte (0) transfer |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
A software write to the control word can land in the same cycle as the acknowledge that reaches terminal count. In that cycle the stop logic wants to clear the start bit, while the write with bit 2 set wants to set it. The bench provokes this collision by driving `xfer_ack` and the control write on the same edge. It then judges that the start bit reads 1, that the count still decremented to 0, and that the interrupt still pulses from the old control word. It also judges that the new reserved sync value keeps the bus quiet.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int CTL_W = 16;

    // control word bit positions
    localparam int B_WORD  = 0;
    localparam int B_START = 1;
    localparam int B_CHG   = 2;
    localparam int B_EXT   = 3;
    localparam int B_TMR   = 4;
    localparam int B_SYNLO = 6;
    localparam int B_SYNHI = 7;
    localparam int B_IEN   = 8;
    localparam int B_TC    = 9;
    localparam int B_SINC  = 10;
    localparam int B_SDEC  = 11;
    localparam int B_SMEM  = 12;
    localparam int B_DINC  = 13;
    localparam int B_DDEC  = 14;
    localparam int B_DMEM  = 15;

    localparam logic [CTL_W-1:0] CTL_RESET = 16'h00C0;

    typedef enum logic [1:0] {
        SYNC_NONE = 2'b00,
        SYNC_SRC  = 2'b01,
        SYNC_DST  = 2'b10,
        SYNC_RSVD = 2'b11
    } sync_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUS   = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        SEL_CTL = 2'd0,
        SEL_SRC = 2'd1,
        SEL_DST = 2'd2,
        SEL_CNT = 2'd3
    } sel_e;
endpackage

// File: rtl/dmach_step.sv
module dmach_step #(
    parameter int W = 20
) (
    input  logic [W-1:0] ptr,
    input  logic         up,
    input  logic         down,
    input  logic         word,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    logic [W-1:0] delta;

    always_comb begin
        delta = word ? TWO : ONE;
        unique case ({up, down})
            2'b10:   nxt = ptr + delta;
            2'b01:   nxt = ptr - delta;
            default: nxt = ptr;
        endcase
    end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [ADDR_W-1:0]      wr_data,
    input  logic                   adv,
    input  logic                   stop,
    input  logic [1:0][ADDR_W-1:0] ptr_nxt,
    output logic [CTL_W-1:0]       ctl_q,
    output logic [1:0][ADDR_W-1:0] ptr_q,
    output logic [CNT_W-1:0]       cnt_q
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CTL_W-1:0] ctl_wr;
    logic [CTL_W-1:0] ctl_new;
    logic             start_keep;

    always_comb begin
        ctl_wr     = wr_data[CTL_W-1:0];
        start_keep = ctl_q[B_START] & ~stop;
        ctl_new    = ctl_wr;
        ctl_new[B_CHG]   = 1'b0;
        ctl_new[B_START] = ctl_wr[B_CHG] ? ctl_wr[B_START] : start_keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr_en && wr_sel == SEL_CTL) begin
            ctl_q <= ctl_new;
        end else if (stop) begin
            ctl_q[B_START] <= 1'b0;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        localparam logic [1:0] MY_SEL = (g == 0) ? SEL_SRC : SEL_DST;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (wr_en && wr_sel == MY_SEL) begin
                ptr_q[g] <= wr_data;
            end else if (adv) begin
                ptr_q[g] <= ptr_nxt[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en && wr_sel == SEL_CNT) begin
            cnt_q <= wr_data[CNT_W-1:0];
        end else if (adv) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tmr_mode,
    input  logic             ext_mode,
    input  logic [1:0]       sync,
    input  logic             tc_en,
    input  logic             int_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             drq,
    input  logic             tmr,
    input  logic             ack,
    output logic             adv,
    output logic             stop,
    output logic             xfer_req,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    state_e state_q, state_d;
    logic   go;
    logic   term_en;
    logic   last;

    // request qualification and stop policy
    always_comb begin
        if (tmr_mode) begin
            go      = tmr;
            term_en = tc_en;
        end else begin
            unique case (sync_e'(sync))
                SYNC_NONE: begin go = 1'b1;           term_en = 1'b1;  end
                SYNC_SRC:  begin go = drq & ~ext_mode; term_en = tc_en; end
                SYNC_DST:  begin go = drq & ~ext_mode; term_en = tc_en; end
                default:   begin go = 1'b0;           term_en = tc_en; end
            endcase
        end
        last = (cnt == CNT_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!start)   state_d = ST_IDLE;
                else if (go)  state_d = ST_BUS;
            end
            ST_BUS: begin
                if (ack) state_d = (last && term_en) ? ST_IDLE : ST_ARMED;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        xfer_req = (state_q == ST_BUS);
        adv      = xfer_req & ack;
        stop     = adv & last & term_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= stop & int_en & tc_en;
    end
endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              drq_in,
    input  logic              tmr_req,
    input  logic              xfer_ack,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_src_addr,
    output logic [ADDR_W-1:0] xfer_dst_addr,
    output logic              xfer_src_mem,
    output logic              xfer_dst_mem,
    output logic              xfer_word,
    output logic              irq
);
    logic [CTL_W-1:0]       ctl_q;
    logic [1:0][ADDR_W-1:0] ptr_q;
    logic [1:0][ADDR_W-1:0] ptr_nxt;
    logic [CNT_W-1:0]       cnt_q;
    logic                   adv;
    logic                   stop;

    dmach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .adv     (adv),
        .stop    (stop),
        .ptr_nxt (ptr_nxt),
        .ctl_q   (ctl_q),
        .ptr_q   (ptr_q),
        .cnt_q   (cnt_q)
    );

    for (genvar g = 0; g < 2; g++) begin : g_step
        localparam int UP_BIT = (g == 0) ? B_SINC : B_DINC;
        localparam int DN_BIT = (g == 0) ? B_SDEC : B_DDEC;
        dmach_step #(.W(ADDR_W)) u_step (
            .ptr  (ptr_q[g]),
            .up   (ctl_q[UP_BIT]),
            .down (ctl_q[DN_BIT]),
            .word (ctl_q[B_WORD]),
            .nxt  (ptr_nxt[g])
        );
    end

    dmach_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ctl_q[B_START]),
        .tmr_mode (ctl_q[B_TMR]),
        .ext_mode (ctl_q[B_EXT]),
        .sync     (ctl_q[B_SYNHI:B_SYNLO]),
        .tc_en    (ctl_q[B_TC]),
        .int_en   (ctl_q[B_IEN]),
        .cnt      (cnt_q),
        .drq      (drq_in),
        .tmr      (tmr_req),
        .ack      (xfer_ack),
        .adv      (adv),
        .stop     (stop),
        .xfer_req (xfer_req),
        .irq      (irq)
    );

    always_comb begin
        unique case (sel_e'(rd_sel))
            SEL_CTL: rd_data = ADDR_W'(ctl_q);
            SEL_SRC: rd_data = ptr_q[0];
            SEL_DST: rd_data = ptr_q[1];
            default: rd_data = ADDR_W'(cnt_q);
        endcase
        xfer_src_addr = ptr_q[0];
        xfer_dst_addr = ptr_q[1];
        xfer_src_mem  = ctl_q[B_SMEM];
        xfer_dst_mem  = ctl_q[B_DMEM];
        xfer_word     = ctl_q[B_WORD];
    end
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic              xfer_req,
    input logic              xfer_ack,
    input logic [ADDR_W-1:0] xfer_src_addr,
    input logic [ADDR_W-1:0] xfer_dst_addr,
    input logic              irq,
    input logic [15:0]       ctl_q,
    input logic [CNT_W-1:0]  cnt_q
);
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> xfer_req);

    p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && !wr_en) |=> ($stable(xfer_src_addr) && $stable(xfer_dst_addr)));

    p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !wr_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_req && xfer_ack && ctl_q[8] && ctl_q[9]) |=> !irq);

    p_rsvd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_req && !ctl_q[4] && ctl_q[7:6] == 2'b11) |=> !xfer_req);

    p_ext_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_req && !ctl_q[4] && ctl_q[3] && ctl_q[7:6] != 2'b00) |=> !xfer_req);

    p_start_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !wr_data[2] && !(xfer_req && xfer_ack))
            |=> (ctl_q[1] == $past(ctl_q[1])));
endmodule

bind dmach_top dmach_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .xfer_req      (xfer_req),
    .xfer_ack      (xfer_ack),
    .xfer_src_addr (xfer_src_addr),
    .xfer_dst_addr (xfer_dst_addr),
    .irq           (irq),
    .ctl_q         (ctl_q),
    .cnt_q         (cnt_q)
);

// File: tb/dmach_top_bench.sv
module dmach_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int CW = 16;
    localparam logic [AW-1:0] AMASK = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic [1:0]    rd_sel = '0;
    logic [AW-1:0] rd_data;
    logic          drq_in = 1'b0;
    logic          tmr_req = 1'b0;
    logic          xfer_ack = 1'b0;
    logic          xfer_req;
    logic [AW-1:0] xfer_src_addr;
    logic [AW-1:0] xfer_dst_addr;
    logic          xfer_src_mem;
    logic          xfer_dst_mem;
    logic          xfer_word;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    dmach_top #(.ADDR_W(AW), .CNT_W(CW)) u_dmach_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .drq_in(drq_in), .tmr_req(tmr_req),
        .xfer_ack(xfer_ack), .xfer_req(xfer_req), .xfer_src_addr(xfer_src_addr),
        .xfer_dst_addr(xfer_dst_addr), .xfer_src_mem(xfer_src_mem),
        .xfer_dst_mem(xfer_dst_mem), .xfer_word(xfer_word), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit word, input bit start, input bit chg,
        input bit ext, input bit tmr, input bit [1:0] syn, input bit ien, input bit tc,
        input bit sinc, input bit sdec, input bit smem, input bit dinc, input bit ddec,
        input bit dmem);
        return {dmem, ddec, dinc, smem, sdec, sinc, tc, ien, syn, 1'b0, tmr, ext, chg, start, word};
    endfunction

    function automatic logic [AW-1:0] nstep(input logic [AW-1:0] p, input bit up,
        input bit dn, input bit word);
        logic [AW-1:0] d = word ? AW'(2) : AW'(1);
        if (up && !dn) return (p + d) & AMASK;
        if (dn && !up) return (p - d) & AMASK;
        return p;
    endfunction

    task automatic wr(input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sel, output logic [AW-1:0] v);
        rd_sel = sel[1:0];
        #1;
        v = rd_data;
    endtask

    task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d,
        input logic [15:0] cnt, input logic [15:0] c);
        wr(1, s); wr(2, d); wr(3, AW'(cnt)); wr(0, AW'(c));
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen |= xfer_req;
        end
        check(tag, seen, 1'b0);
    endtask

    task automatic serve(input int n, input logic [15:0] c, inout logic [AW-1:0] s,
        inout logic [AW-1:0] d, inout logic [15:0] cnt);
        logic [AW-1:0] v;
        for (int i = 0; i < n; i++) begin
            int t = 0;
            while (!xfer_req && t < 40) begin
                @(negedge clk);
                t++;
            end
            check("R12 request raised", xfer_req, 1'b1);
            check("R3 source address", xfer_src_addr, s);
            check("R3 destination address", xfer_dst_addr, d);
            check("R4 attribute bits", {xfer_src_mem, xfer_dst_mem, xfer_word},
                  {c[12], c[15], c[0]});
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
            s = nstep(s, c[10], c[11], c[0]);
            d = nstep(d, c[13], c[14], c[0]);
            cnt = cnt - 16'd1;
            rd(3, v);
            check("R5 count after transfer", v, AW'(cnt));
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] v, s, d;
        logic [15:0]   c, cnt;
        void'($urandom(32'd5150));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(0, v); check("R1 control reset", v, 20'h000C0);
        rd(1, v); check("R1 source reset", v, 0);
        rd(2, v); check("R1 destination reset", v, 0);
        rd(3, v); check("R1 count reset", v, 0);
        check("R1 request idle", xfer_req, 1'b0);
        check("R1 irq idle", irq, 1'b0);

        // R2 start guarded by bit 2; R11 reserved sync issues nothing
        c = mk(0,1,0, 0,0,2'b11, 0,0, 1,0,1, 1,0,1);
        setup(20'h100, 20'h200, 16'd4, c);
        rd(0, v); check("R2 start ignored without change bit", v[1], 1'b0);
        c[2] = 1'b1;
        wr(0, AW'(c));
        rd(0, v); check("R2 start written with change bit", v[1], 1'b1);
        check("R2 bit 2 reads zero", v[2], 1'b0);
        quiet(12, "R11 reserved sync quiet");
        rd(3, v); check("R11 count untouched", v, 4);
        wr(0, AW'(c & 16'hFFFB));
        rd(0, v); check("R2 start kept on write without change bit", v[1], 1'b1);
        wr(0, AW'(mk(0,0,1, 0,0,2'b11, 0,0, 0,0,0, 0,0,0)));

        // R6 unsynchronized byte run with interrupt, R8 pulse
        c = mk(0,1,1, 0,0,2'b00, 1,1, 1,0,1, 0,1,0);
        s = 20'hFFFFF; d = 20'h00001; cnt = 16'd3;
        setup(s, d, cnt, c);
        serve(3, c, s, d, cnt);
        check("R8 irq pulse at terminal count", irq, 1'b1);
        rd(0, v); check("R6 start cleared at count 0", v[1], 1'b0);
        @(negedge clk);
        check("R8 irq one cycle", irq, 1'b0);
        quiet(6, "R6 no transfer after stop");

        // R6 unsync stops with TC=0, R8 no irq, R3 hold on equal bits
        c = mk(1,1,1, 0,0,2'b00, 1,0, 1,1,0, 0,0,1);
        s = 20'h00400; d = 20'h00800; cnt = 16'd2;
        setup(s, d, cnt, c);
        serve(2, c, s, d, cnt);
        check("R8 no irq without terminal-count bit", irq, 1'b0);
        rd(0, v); check("R6 unsync stops regardless of bit 9", v[1], 1'b0);
        rd(1, v); check("R3 source held on equal bits", v, 20'h00400);

        // R7 source sync waits for drq, stops with TC=1
        c = mk(1,1,1, 0,0,2'b01, 0,1, 1,0,1, 1,0,1);
        s = 20'h01000; d = 20'h02000; cnt = 16'd2;
        setup(s, d, cnt, c);
        quiet(10, "R7 source sync waits for request pin");
        drq_in = 1'b1;
        serve(2, c, s, d, cnt);
        rd(0, v); check("R7 sync stops at 0 with bit 9", v[1], 1'b0);
        drq_in = 1'b0;

        // R7 destination sync TC=0 keeps running, R5 wrap
        c = mk(0,1,1, 0,0,2'b10, 1,0, 0,1,0, 1,0,0);
        s = 20'h00010; d = 20'h00020; cnt = 16'd1;
        setup(s, d, cnt, c);
        drq_in = 1'b1;
        serve(3, c, s, d, cnt);
        drq_in = 1'b0;
        rd(3, v); check("R5 count wrapped to FFFE", v, 20'h0FFFE);
        rd(0, v); check("R7 sync without bit 9 keeps running", v[1], 1'b1);
        check("R8 no irq on wrap", irq, 1'b0);
        wr(0, AW'(mk(0,0,1, 0,0,2'b10, 0,0, 0,0,0, 0,0,0)));

        // R10 request pin used as interrupt input
        c = mk(0,1,1, 1,0,2'b01, 0,1, 1,0,0, 0,0,0);
        setup(20'h0, 20'h0, 16'd2, c);
        drq_in = 1'b1;
        quiet(10, "R10 request pin ignored");
        rd(3, v); check("R10 count untouched", v, 2);
        drq_in = 1'b0;
        wr(0, AW'(mk(0,0,1, 1,0,2'b01, 0,0, 0,0,0, 0,0,0)));

        // R9 timer request overrides reserved sync field
        c = mk(0,1,1, 0,1,2'b11, 1,1, 1,0,0, 1,0,0);
        s = 20'h00300; d = 20'h00500; cnt = 16'd1;
        setup(s, d, cnt, c);
        drq_in = 1'b1;
        quiet(10, "R9 no transfer without timer request");
        tmr_req = 1'b1;
        serve(1, c, s, d, cnt);
        check("R9 irq in timer mode", irq, 1'b1);
        rd(0, v); check("R9 timer run stops with bit 9", v[1], 1'b0);
        tmr_req = 1'b0; drq_in = 1'b0;

        // R13 control write collides with terminal-count acknowledge
        c = mk(0,1,1, 0,0,2'b00, 1,1, 1,0,0, 0,0,0);
        setup(20'h00050, 20'h00060, 16'd1, c);
        begin
            int t = 0;
            while (!xfer_req && t < 40) begin
                @(negedge clk);
                t++;
            end
        end
        check("R12 request before collision", xfer_req, 1'b1);
        xfer_ack = 1'b1;
        wr_en = 1'b1; wr_sel = 2'd0;
        wr_data = AW'(mk(0,1,1, 0,0,2'b11, 0,0, 0,0,0, 0,0,0));
        @(negedge clk);
        xfer_ack = 1'b0; wr_en = 1'b0;
        rd(0, v); check("R13 write wins over stop", v[1], 1'b1);
        rd(3, v); check("R13 count still decremented", v, 0);
        check("R13 irq from old control word", irq, 1'b1);
        quiet(8, "R13 reserved sync after collision");
        wr(0, AW'(mk(0,0,1, 0,0,2'b11, 0,0, 0,0,0, 0,0,0)));

        // random unsynchronized runs
        for (int it = 0; it < 25; it++) begin
            bit w = $urandom % 2;
            bit tc = $urandom % 2;
            logic [3:0] m = 4'($urandom);
            c = mk(w,1,1, 0,0,2'b00, 1,tc, m[0],m[1],$urandom%2, m[2],m[3],$urandom%2);
            s = AW'($urandom) & AMASK;
            d = AW'($urandom) & AMASK;
            cnt = 16'(1 + $urandom % 5);
            setup(s, d, cnt, c);
            serve(int'(cnt), c, s, d, cnt);
            check("R8 random irq follows bit 9", irq, tc);
            rd(0, v); check("R6 random run stopped", v[1], 1'b0);
            rd(1, v); check("R3 random source final", v, s);
            rd(2, v); check("R3 random destination final", v, d);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule